// File: doc/BRIEF.md
# Sixteen-Function Parametric ALU

This block is a purely combinational arithmetic and logic unit. It takes two operands of width N and a four-bit function code, and it returns one N-bit result. The highest bit of the function code picks which of two internal engines drives the result. Codes whose highest bit is clear go to the arithmetic engine. Codes whose highest bit is set go to the bitwise engine.

The arithmetic engine holds exactly one N-bit two's complement adder/subtractor. Every arithmetic function passes through it: pass-through of either operand, plus or minus one on either operand, the sum, and the difference. The engine's steering logic selects the first operand, selects a second operand (zero, one, or b), and sets the subtract control. That control drives the carry-in and also inverts every bit of the second operand. All results wrap modulo 2^N. There is no carry, overflow or other flag output.

The block has no clock and no storage. A datapath uses it directly between its own pipeline registers.

Top module: `opsel_alu`

## Requirements
- R1: Function code bit 3 selects the engine: 0 selects the arithmetic result and 1 selects the bitwise result.
- R2: Code 4'b0000 returns a unchanged, and code 4'b0011 returns b unchanged.
- R3: Code 4'b0001 returns a+1, and code 4'b0100 returns b+1, each modulo 2^N (all-ones wraps to zero).
- R4: Code 4'b0010 returns a-1, and code 4'b0101 returns b-1, each modulo 2^N (zero wraps to all-ones).
- R5: Code 4'b0110 returns a+b modulo 2^N, and the carry out of the top bit is discarded.
- R6: Code 4'b0111 returns a-b modulo 2^N (two's complement difference).
- R7: Code 4'b1000 returns the bitwise inverse of a, and code 4'b1001 returns the bitwise inverse of b.
- R8: Code 4'b1010 returns a AND b, and code 4'b1011 returns a OR b.
- R9: Code 4'b1100 returns NOT(a AND b), and code 4'b1101 returns NOT(a OR b).
- R10: Code 4'b1110 returns a XOR b, and code 4'b1111 returns NOT(a XOR b).
- R11: Width N is a parameter, and the result follows any input change within the same time step, with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | First operand |
| b | input | N | Second operand |
| sel | input | 4 | Function code; bit 3 picks the engine |
| y | output | N | Result |

## Verification
At N=4, the bench applies every combination of the function code and both operands. This full sweep covers every carry chain length and every wrap point in the shared adder. At N=8, the bench crosses the operands zero, one, 0x7F, 0x80, 0xAA and all-ones over every code. These values separate wrap-around on increment and decrement from plain arithmetic, and they show whether constant steering reached the correct operand. Random 8-bit operands then exercise the middle bits. One further check changes the operands with no clock edge between the change and the sample, so it separates a combinational output from a registered one.

// File: rtl/opsel_alu_pkg.sv
package opsel_alu_pkg;
  // Lower three bits of the function code, arithmetic half
  typedef enum logic [2:0] {
    AR_PASS_A = 3'b000,
    AR_INC_A  = 3'b001,
    AR_DEC_A  = 3'b010,
    AR_PASS_B = 3'b011,
    AR_INC_B  = 3'b100,
    AR_DEC_B  = 3'b101,
    AR_ADD    = 3'b110,
    AR_SUB    = 3'b111
  } arith_fn_e;

  // Lower three bits of the function code, bitwise half
  typedef enum logic [2:0] {
    LG_NOT_A = 3'b000,
    LG_NOT_B = 3'b001,
    LG_AND   = 3'b010,
    LG_OR    = 3'b011,
    LG_NAND  = 3'b100,
    LG_NOR   = 3'b101,
    LG_XOR   = 3'b110,
    LG_XNOR  = 3'b111
  } logic_fn_e;

  // Second-operand source for the shared adder
  typedef enum logic [1:0] {
    OPB_ZERO = 2'd0,
    OPB_ONE  = 2'd1,
    OPB_B    = 2'd2
  } opb_src_e;
endpackage

// File: rtl/opsel_fa_cell.sv
module opsel_fa_cell (
  input  logic ci,
  input  logic x,
  input  logic y,
  output logic s,
  output logic co
);
  assign s  = x ^ y ^ ci;
  assign co = (x & y) | (x & ci) | (y & ci);
endmodule

// File: rtl/opsel_addsub.sv
module opsel_addsub #(
  parameter int N = 8
) (
  input  logic         sub,
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  output logic [N-1:0] s
);
  logic [N-1:0] c;
  logic [N-1:0] y_t;

  assign c[0] = sub;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign y_t[i] = y[i] ^ sub;
    if (i < N-1) begin : g_full
      opsel_fa_cell u_fa (
        .ci (c[i]),
        .x  (x[i]),
        .y  (y_t[i]),
        .s  (s[i]),
        .co (c[i+1])
      );
    end else begin : g_top
      // carry out of the top bit wraps away, so only the sum is built
      assign s[i] = x[i] ^ y_t[i] ^ c[i];
    end
  end

  // R5 R6: the ripple chain matches modular add or subtract
  always_comb begin
    if (!$isunknown({sub, x, y})) begin
      addsub_wrap_chk: assert (s == (sub ? N'(x - y) : N'(x + y)))
        else $error("adder chain mismatch");
    end
  end
endmodule

// File: rtl/opsel_arith_unit.sv
module opsel_arith_unit
  import opsel_alu_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [2:0]   fn,
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] r
);
  localparam logic [N-1:0] K_ZERO = '0;
  localparam logic [N-1:0] K_ONE  = N'(1);

  arith_fn_e    op;
  opb_src_e     src_b;
  logic         use_b_first;
  logic         sub;
  logic [N-1:0] opx;
  logic [N-1:0] opy;

  assign op = arith_fn_e'(fn);

  always_comb begin
    use_b_first = 1'b0;
    src_b       = OPB_ZERO;
    sub         = 1'b0;
    unique case (op)
      AR_PASS_A: ;
      AR_INC_A:  src_b = OPB_ONE;
      AR_DEC_A:  begin src_b = OPB_ONE; sub = 1'b1; end
      AR_PASS_B: use_b_first = 1'b1;
      AR_INC_B:  begin use_b_first = 1'b1; src_b = OPB_ONE; end
      AR_DEC_B:  begin use_b_first = 1'b1; src_b = OPB_ONE; sub = 1'b1; end
      AR_ADD:    src_b = OPB_B;
      AR_SUB:    begin src_b = OPB_B; sub = 1'b1; end
      default:   ;
    endcase
  end

  assign opx = use_b_first ? b : a;

  always_comb begin
    unique case (src_b)
      OPB_ONE: opy = K_ONE;
      OPB_B:   opy = b;
      default: opy = K_ZERO;
    endcase
  end

  opsel_addsub #(.N(N)) u_addsub (
    .sub (sub),
    .x   (opx),
    .y   (opy),
    .s   (r)
  );

  always_comb begin
    if (!$isunknown({fn, a, b})) begin
      // R2
      pass_through_chk: assert (!(op == AR_PASS_A || op == AR_PASS_B) || r == opx)
        else $error("transfer altered operand");
      // R3
      inc_step_chk: assert (!(op == AR_INC_A || op == AR_INC_B) || N'(r - opx) == K_ONE)
        else $error("increment step wrong");
      // R4
      dec_step_chk: assert (!(op == AR_DEC_A || op == AR_DEC_B) || N'(opx - r) == K_ONE)
        else $error("decrement step wrong");
    end
  end
endmodule

// File: rtl/opsel_logic_unit.sv
module opsel_logic_unit
  import opsel_alu_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [2:0]   fn,
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] r
);
  logic_fn_e    op;
  logic [N-1:0] base;
  logic         inv;

  assign op = logic_fn_e'(fn);

  // one base function per pair, optional output inversion by code
  always_comb begin
    unique case (op)
      LG_NOT_A:          base = a;
      LG_NOT_B:          base = b;
      LG_AND,  LG_NAND:  base = a & b;
      LG_OR,   LG_NOR:   base = a | b;
      LG_XOR,  LG_XNOR:  base = a ^ b;
      default:           base = a;
    endcase
  end

  always_comb begin
    unique case (op)
      LG_NOT_A, LG_NOT_B, LG_NAND, LG_NOR, LG_XNOR: inv = 1'b1;
      default:                                      inv = 1'b0;
    endcase
  end

  assign r = inv ? ~base : base;

  always_comb begin
    if (!$isunknown({fn, a, b})) begin
      // R8
      and_or_chk: assert (!(op == LG_AND) || ((r & ~a) == '0 && (r & ~b) == '0))
        else $error("AND result has bits outside operands");
      // R9
      nor_chk: assert (!(op == LG_NOR) || ((r & a) == '0 && (r & b) == '0))
        else $error("NOR result overlaps an operand");
    end
  end
endmodule

// File: rtl/opsel_alu.sv
module opsel_alu
  import opsel_alu_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic [3:0]   sel,
  output logic [N-1:0] y
);
  localparam int FN_W = 3;

  logic [FN_W-1:0] fn;
  logic [N-1:0]    y_arith;
  logic [N-1:0]    y_logic;

  assign fn = sel[FN_W-1:0];

  opsel_arith_unit #(.N(N)) u_arith (
    .fn (fn),
    .a  (a),
    .b  (b),
    .r  (y_arith)
  );

  opsel_logic_unit #(.N(N)) u_logic (
    .fn (fn),
    .a  (a),
    .b  (b),
    .r  (y_logic)
  );

  assign y = sel[3] ? y_logic : y_arith;

  always_comb begin
    if (!$isunknown({sel, a, b})) begin
      // R7
      invert_a_chk: assert (!(sel == 4'b1000) || (y ^ a) == {N{1'b1}})
        else $error("complement of a wrong");
      // R10
      xor_port_chk: assert (!(sel == 4'b1110) || (y ^ a ^ b) == '0)
        else $error("xor result wrong");
      // R1
      split_chk: assert (!(sel[3] == 1'b0 && sel[2:0] == 3'b000) || y == a)
        else $error("arithmetic half not routed");
    end
  end
endmodule

// File: tb/test_opsel_alu.sv
module test_opsel_alu;
  localparam int NA = 4;
  localparam int NB = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic [NA-1:0] a4 = '0, b4 = '0;
  logic [3:0]    s4 = '0;
  logic [NA-1:0] y4;
  logic [NB-1:0] a8 = '0, b8 = '0;
  logic [3:0]    s8 = '0;
  logic [NB-1:0] y8;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  opsel_alu #(.N(NA)) i_opsel_alu (.a(a4), .b(b4), .sel(s4), .y(y4));
  opsel_alu #(.N(NB)) i_opsel_alu_w8 (.a(a8), .b(b8), .sel(s8), .y(y8));

  function automatic logic [63:0] model(input int w, input logic [3:0] s,
                                        input logic [63:0] x, input logic [63:0] z);
    logic [63:0] m, r;
    m = (64'd1 << w) - 64'd1;
    case (s)
      4'h0: r = x;       4'h1: r = x + 1;     4'h2: r = x - 1;      4'h3: r = z;
      4'h4: r = z + 1;   4'h5: r = z - 1;     4'h6: r = x + z;      4'h7: r = x - z;
      4'h8: r = ~x;      4'h9: r = ~z;        4'hA: r = x & z;      4'hB: r = x | z;
      4'hC: r = ~(x & z); 4'hD: r = ~(x | z); 4'hE: r = x ^ z;      default: r = ~(x ^ z);
    endcase
    return r & m;
  endfunction

  function automatic string tag(input logic [3:0] s);
    case (s)
      4'h0, 4'h3: return "R2";
      4'h1, 4'h4: return "R3";
      4'h2, 4'h5: return "R4";
      4'h6:       return "R5";
      4'h7:       return "R6";
      4'h8, 4'h9: return "R7";
      4'hA, 4'hB: return "R8";
      4'hC, 4'hD: return "R9";
      default:    return "R10";
    endcase
  endfunction

  task automatic compare(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic vec(input int w, input logic [3:0] s, input logic [63:0] x, input logic [63:0] z);
    @(posedge clk);
    if (w == NA) begin a4 = x[NA-1:0]; b4 = z[NA-1:0]; s4 = s; end
    else         begin a8 = x[NB-1:0]; b8 = z[NB-1:0]; s8 = s; end
    @(negedge clk);
    compare(tag(s), (w == NA) ? {60'd0, y4} : {56'd0, y8}, model(w, s, x, z));
  endtask

  initial begin
    logic [7:0] edges [6];
    edges = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hAA, 8'hFF};
    @(negedge clk);
    // R1: same operands, code bit 3 toggles the engine
    a8 = 8'h3C; b8 = 8'h0F; s8 = 4'b0000; #1;
    compare("R1", {56'd0, y8}, 64'h3C);
    s8 = 4'b1000; #1;
    compare("R1", {56'd0, y8}, 64'hC3);
    // R11: operand change seen without any clock edge
    a8 = 8'hFF; b8 = 8'h01; s8 = 4'b0110; #0.5;
    compare("R11", {56'd0, y8}, 64'h00);
    // Exhaustive sweep at width 4
    for (int s = 0; s < 16; s++)
      for (int x = 0; x < 16; x++)
        for (int z = 0; z < 16; z++)
          vec(NA, 4'(s), 64'(x), 64'(z));
    // Edge operands at width 8
    for (int s = 0; s < 16; s++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          vec(NB, 4'(s), {56'd0, edges[i]}, {56'd0, edges[j]});
    // Random operands at width 8
    for (int k = 0; k < 2000; k++)
      vec(NB, 4'($urandom_range(15)), 64'($urandom_range(255)), 64'($urandom_range(255)));
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule